// File: doc/BRIEF.md
# SPI Baud Divider Selector

This block turns a requested serial bit rate into a two-part clock setting for a fixed main clock. The setting has a coarse power-of-two prescaler code `div_sel` (0..3) and a fine count `brg_sel` (4..63). The intermediate clock is the main clock divided by `2 << div_sel`. The serial clock is that intermediate clock divided by `2*(brg_sel+1)`. The main clock frequency is the elaboration parameter `MAIN_HZ`. A `start` strobe hands over a requested rate, and a single-cycle `done` pulse reports that the new setting is in place.

The calculation runs one step per cycle and uses no combinational divider. An iterative restoring divider first forms `MAIN_HZ / rate`, one quotient bit per cycle. A search then tries the prescaler codes in ascending order, one code per cycle. Each step shifts the quotient right by `2 + code` and looks for a fine count that fits. The search clamps to the fastest setting when the rate is too fast and to the slowest setting when the rate is too slow.

Two constant outputs give the legal rate window. A clock generator runs from the selected fields and produces a clock-enable tick train and a toggling serial clock.

Top module: `spi_baud_sel`

## Requirements
- R1: `rate_max` equals `MAIN_HZ/20` and `rate_min` equals `MAIN_HZ/2049 + 1`, both using integer division.
- R2: Let Q be `floor(MAIN_HZ/rate)` and let q(k) be `floor(Q / (4 << k))`. The chosen `div_sel` is the smallest k in 0..3 with q(k) ≤ 64, and `brg_sel` is q(k) − 1.
- R3: If q(0) < 5, the rate is too fast, and the result is `div_sel`=0, `brg_sel`=4.
- R4: If q(k) > 64 for every k in 0..3, the rate is too slow, and the result is `div_sel`=3, `brg_sel`=63.
- R5: A requested rate of 0 gives the slowest setting, `div_sel`=3 and `brg_sel`=63.
- R6: Count cycles from the clock edge that samples `start`. `done` is high for exactly one cycle, `RATE_W + 2 + div_sel` cycles after that edge. `div_sel` and `brg_sel` take their new values in that same cycle and hold them until the next `done`.
- R7: A `start` pulse that arrives while a calculation is in progress is ignored. It causes no extra `done`, and the pending result comes from the first rate.
- R8: `sclk_tick` is high for one cycle every `(brg_sel+1) << (div_sel+1)` main-clock cycles. `sclk` inverts after each cycle in which `sclk_tick` is high and changes at no other time.
- R9: After reset, `div_sel`=0, `brg_sel`=4, `done`=0 and `sclk`=0.
- R10: `brg_sel` always lies within 4..63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Strobe that begins a calculation for `rate` |
| rate | input | RATE_W | Requested serial bit rate in Hz |
| div_sel | output | 2 | Prescaler code (intermediate clock = main / (2 << code)) |
| brg_sel | output | 6 | Fine count (serial clock = intermediate / (2*(count+1))) |
| done | output | 1 | One-cycle pulse when a new setting is applied |
| rate_min | output | RATE_W | Lowest legal rate |
| rate_max | output | RATE_W | Highest legal rate |
| sclk_tick | output | 1 | Clock-enable tick; one per serial clock half period |
| sclk | output | 1 | Serial clock |

## Verification
The bench builds the block with `MAIN_HZ` = 48,000,000 and `RATE_W` = 32. With these values every prescaler code is reached by an ordinary rate between 20 kHz and 2.4 MHz. The q(0) = 64 / 65 boundary sits at 187.5 kHz and 184 kHz, and the legal window comes out as 23,427 to 2,400,000 Hz. With these values the largest tick period is 1024 cycles, so a tick spacing can be measured for every vector, including both clamps and the zero rate.

// File: rtl/sbd_pkg.sv
`timescale 1ns/1ps
package sbd_pkg;
    localparam int DIV_W   = 2;
    localparam int BRG_W   = 6;
    localparam int BRG_LO  = 4;
    localparam int BRG_HI  = 63;
    localparam int Q_LIMIT = BRG_HI + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_SEARCH = 2'd2
    } sel_state_e;

    typedef struct packed {
        sel_state_e       state;
        logic [DIV_W-1:0] idx;
        logic [DIV_W-1:0] div;
        logic [BRG_W-1:0] brg;
        logic             done;
    } sel_reg_t;
endpackage

// File: rtl/sbd_divider.sv
`timescale 1ns/1ps
// Iterative restoring divider: one quotient bit per cycle, W cycles per result.
module sbd_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          valid;
    } div_reg_t;

    div_reg_t     r_q, r_d;
    logic [W+1:0] trial;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        trial     = {1'b0, r_q.rem, r_q.quo[W-1]} - {2'b00, r_q.dvs};
        if (!r_q.busy) begin
            if (start) begin
                r_d.rem  = '0;
                r_d.quo  = dividend;
                r_d.dvs  = divisor;
                r_d.cnt  = '0;
                r_d.busy = 1'b1;
            end
        end else begin
            if (!trial[W+1]) begin
                r_d.rem = trial[W-1:0];
                r_d.quo = {r_q.quo[W-2:0], 1'b1};
            end else begin
                r_d.rem = {r_q.rem[W-2:0], r_q.quo[W-1]};
                r_d.quo = {r_q.quo[W-2:0], 1'b0};
            end
            r_d.cnt = r_q.cnt + 1'b1;
            if (r_q.cnt == CW'(W-1)) begin
                r_d.busy  = 1'b0;
                r_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid    = r_q.valid;
    assign quotient = r_q.quo;
endmodule

// File: rtl/sbd_step.sv
`timescale 1ns/1ps
// One search step: judges the fine count for a given prescaler code.
module sbd_step
    import sbd_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]     quot,
    input  logic [DIV_W-1:0] idx,
    output logic             accept,
    output logic [DIV_W-1:0] div_pick,
    output logic [BRG_W-1:0] brg_pick
);
    logic [W-1:0] q;

    always_comb begin
        q        = quot >> (32'(idx) + 32'd2);
        accept   = 1'b0;
        div_pick = idx;
        brg_pick = BRG_W'(BRG_LO);
        if (idx == '0 && q < W'(BRG_LO + 1)) begin
            accept   = 1'b1;                       // too fast: fastest legal
            div_pick = '0;
            brg_pick = BRG_W'(BRG_LO);
        end else if (q <= W'(Q_LIMIT)) begin
            accept   = 1'b1;
            brg_pick = q[BRG_W-1:0] - 1'b1;
        end else if (idx == DIV_W'(3)) begin
            accept   = 1'b1;                       // too slow: slowest legal
            div_pick = DIV_W'(3);
            brg_pick = BRG_W'(BRG_HI);
        end
    end
endmodule

// File: rtl/sbd_clkgen.sv
`timescale 1ns/1ps
// Tick every (brg+1) << (div+1) cycles; serial clock toggles per tick.
module sbd_clkgen
    import sbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    input  logic [BRG_W-1:0] brg,
    output logic             tick,
    output logic             sclk
);
    localparam int CNT_W = BRG_W + (1 << DIV_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk;
    } gen_reg_t;

    gen_reg_t         r_q, r_d;
    logic [CNT_W-1:0] period_m1;

    always_comb begin
        period_m1 = ((CNT_W'(brg) + 1'b1) << ({1'b0, div} + 3'd1)) - 1'b1;
        tick      = (r_q.cnt >= period_m1);
        r_d       = r_q;
        if (tick)            r_d.sclk = ~r_q.sclk;
        if (tick || restart) r_d.cnt  = '0;
        else                 r_d.cnt  = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk = r_q.sclk;
endmodule

// File: rtl/spi_baud_sel.sv
`timescale 1ns/1ps
module spi_baud_sel
    import sbd_pkg::*;
#(
    parameter int MAIN_HZ = 100_000_000,
    parameter int RATE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate,
    output logic [1:0]        div_sel,
    output logic [5:0]        brg_sel,
    output logic              done,
    output logic [RATE_W-1:0] rate_min,
    output logic [RATE_W-1:0] rate_max,
    output logic              sclk_tick,
    output logic              sclk
);
    localparam int FAST_DIVISOR = 2 * 2 * (BRG_LO + 1);
    localparam int SLOW_DIVISOR = (2 << 3) * 2 * (BRG_HI + 1) + 1;

    sel_reg_t          r_q, r_d;
    logic              div_go;
    logic              div_valid;
    logic [RATE_W-1:0] quot;
    logic              step_ok;
    logic [DIV_W-1:0]  step_div;
    logic [BRG_W-1:0]  step_brg;

    sbd_divider #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .dividend (RATE_W'(MAIN_HZ)),
        .divisor  (rate),
        .valid    (div_valid),
        .quotient (quot)
    );

    sbd_step #(.W(RATE_W)) u_step (
        .quot     (quot),
        .idx      (r_q.idx),
        .accept   (step_ok),
        .div_pick (step_div),
        .brg_pick (step_brg)
    );

    sbd_clkgen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (r_q.done),
        .div     (r_q.div),
        .brg     (r_q.brg),
        .tick    (sclk_tick),
        .sclk    (sclk)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        div_go   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    div_go    = 1'b1;
                    r_d.state = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_valid) begin
                    r_d.state = ST_SEARCH;
                    r_d.idx   = '0;
                end
            end
            ST_SEARCH: begin
                if (step_ok) begin
                    r_d.div   = step_div;
                    r_d.brg   = step_brg;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.brg   <= BRG_W'(BRG_LO);
        end else begin
            r_q <= r_d;
        end
    end

    assign div_sel  = r_q.div;
    assign brg_sel  = r_q.brg;
    assign done     = r_q.done;
    assign rate_max = RATE_W'(MAIN_HZ / FAST_DIVISOR);
    assign rate_min = RATE_W'(MAIN_HZ / SLOW_DIVISOR + 1);
endmodule

// File: rtl/spi_baud_sel_chk.sv
`timescale 1ns/1ps
module spi_baud_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [1:0] div_sel,
    input logic [5:0] brg_sel,
    input logic       tick,
    input logic       sclk
);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    setting_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({div_sel, brg_sel}));

    // R10
    brg_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_sel >= 6'd4) && (brg_sel <= 6'd63));

    // R8
    sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));

    // R8
    sclk_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sclk != $past(sclk)));
endmodule

bind spi_baud_sel spi_baud_sel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .div_sel (div_sel),
    .brg_sel (brg_sel),
    .tick    (sclk_tick),
    .sclk    (sclk)
);

// File: tb/tb_spi_baud_sel.sv
`timescale 1ns/1ps
module tb_spi_baud_sel;
    localparam int MAIN_HZ = 48_000_000;
    localparam int RATE_W  = 32;
    localparam int NVEC    = 14;

    // {rate, expected div, expected brg}
    localparam logic [39:0] VEC [NVEC] = '{
        {32'd2_400_000, 2'd0, 6'd4 },   // R2 at the max legal rate
        {32'd10_000_000, 2'd0, 6'd4},   // R3 too fast
        {32'd4_800_000, 2'd0, 6'd4 },   // R3 too fast
        {32'd2_000_000, 2'd0, 6'd5 },   // R2
        {32'd1_000_000, 2'd0, 6'd11},   // R2
        {32'd375_000,   2'd0, 6'd31},   // R2
        {32'd187_500,   2'd0, 6'd63},   // R2 q = 64 boundary
        {32'd184_000,   2'd1, 6'd31},   // R2 q = 65 moves to next code
        {32'd100_000,   2'd1, 6'd59},   // R2
        {32'd50_000,    2'd2, 6'd59},   // R2
        {32'd30_000,    2'd3, 6'd49},   // R2
        {32'd20_000,    2'd3, 6'd63},   // R4 too slow
        {32'd1,         2'd3, 6'd63},   // R4 too slow
        {32'd0,         2'd3, 6'd63}    // R5 zero rate
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [RATE_W-1:0] rate = '0;
    logic [1:0]        div_sel;
    logic [5:0]        brg_sel;
    logic              done;
    logic [RATE_W-1:0] rate_min;
    logic [RATE_W-1:0] rate_max;
    logic              sclk_tick;
    logic              sclk;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_baud_sel #(.MAIN_HZ(MAIN_HZ), .RATE_W(RATE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rate(rate),
        .div_sel(div_sel), .brg_sel(brg_sel), .done(done),
        .rate_min(rate_min), .rate_max(rate_max),
        .sclk_tick(sclk_tick), .sclk(sclk)
    );

    task automatic check(input string req, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Start a calculation; return cycles from the sampling edge to done.
    task automatic launch(input logic [RATE_W-1:0] r, output int lat);
        @(negedge clk);
        start = 1'b1;
        rate  = r;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input logic [RATE_W-1:0] r, input logic [1:0] ed,
                           input logic [5:0] eb, input string req);
        int lat;
        int gap;
        int period;
        logic s0;
        launch(r, lat);
        check(req, div_sel, ed, $sformatf("div for rate %0d", r));
        check(req, brg_sel, eb, $sformatf("brg for rate %0d", r));
        check("R6", lat, RATE_W + 2 + ed, "latency to done");
        @(negedge clk);
        check("R6", done, 0, "done width");
        period = (int'(eb) + 1) << (int'(ed) + 1);
        gap = 0;
        while (!sclk_tick && gap < 3000) begin @(negedge clk); gap++; end
        s0 = sclk;
        gap = 0;
        do begin @(negedge clk); gap++; end while (!sclk_tick && gap < 3000);
        check("R8", gap, period, "tick spacing");
        check("R8", sclk, !s0, "sclk toggled once per tick");
    endtask

    initial begin
        #(200_000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        int dones;
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", div_sel, 0, "reset div");
        check("R9", brg_sel, 4, "reset brg");
        check("R9", done, 0, "reset done");
        check("R9", sclk, 0, "reset sclk");
        rst_n = 1'b1;
        @(negedge clk);
        // R1 legal window
        check("R1", rate_max, 2_400_000, "rate_max");
        check("R1", rate_min, 23_427, "rate_min");

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = (i == 1 || i == 2) ? "R3" : (i == 11 || i == 12) ? "R4" :
                  (i == 13) ? "R5" : "R2";
            run_vec(VEC[i][39:8], VEC[i][7:6], VEC[i][5:0], tag);
        end

        // R7: second start while busy is ignored
        @(negedge clk);
        start = 1'b1;
        rate  = 32'd1_000_000;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1;
        rate  = 32'd20_000;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        for (int c = 0; c < 120; c++) begin
            if (done) begin
                dones++;
                check("R7", div_sel, 0, "div keeps first rate");
                check("R7", brg_sel, 11, "brg keeps first rate");
            end
            @(negedge clk);
        end
        check("R7", dones, 1, "done count with busy start");

        // R6: setting holds with no start
        repeat (50) @(negedge clk);
        check("R6", brg_sel, 11, "brg held after done");

        // R2 again after a clamp, back-to-back
        launch(32'd20_000, lat);
        launch(32'd50_000, lat);
        check("R2", div_sel, 2, "div back-to-back");
        check("R2", brg_sel, 59, "brg back-to-back");
        finish_run();
    end
endmodule